// File: doc/BRIEF.md
# Host-stepped DES round engine

This block is a DES coprocessor that a host processor drives one command at a time. It has no round counter and no sequencer of its own. The host loads a 64-bit key and a 64-bit data block. It then issues sixteen round commands, and each command does exactly one Feistel round in a single clock cycle. Finally the host issues a read and collects the 64-bit result as two 32-bit words. Because the direction and the key-rotation amount come with every round command, software fully controls the sequence of rounds. The same hardware therefore serves both encryption and decryption.

All traffic uses one command port with a valid/ready handshake. A command is accepted on a rising clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. Key loads, data loads and reads pass their operand through one register stage, so the port is busy for the cycle after one of them is accepted. Round and key-restore commands never make the port busy. The permuted-choice-1 image of the last key is kept, so software can restore the key schedule without sending the key again.

Top module: `des_round_engine`

## Requirements
- R1: After reset `cmd_ready_o` is high, `rdata_valid_o` is low, and the data halves and key halves are zero, so a read issued before any load returns 0.
- R2: Opcode 0 (key load) takes the key as `{cmd_hi_i, cmd_lo_i}`, with DES bit 1 at bit 63. Permuted choice 1 is applied to it, and the result is split into the 28-bit halves C (upper) and D (lower). The same 56-bit value is also saved for later restore.
- R3: Opcode 1 (data load) applies the initial permutation to `{cmd_hi_i, cmd_lo_i}` and loads the left half (upper 32 bits) and the right half (lower 32 bits).
- R4: Opcode 2 (round) with `cmd_imm_i[0]`=0 encrypts. It first rotates C and D left by 1 (`cmd_imm_i[1]`=0) or by 2 (`cmd_imm_i[1]`=1). It then takes the round key from permuted choice 2 of the rotated halves. The new left half is the old right half, and the new right half is the old left half XOR P(S(E(right) XOR key)). Sixteen such rounds with rotation amounts 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1, followed by a read, give standard DES ciphertext.
- R5: Opcode 2 with `cmd_imm_i[0]`=1 decrypts. It takes the round key from the unrotated halves and then rotates C and D right by the commanded amount. Sixteen such rounds with amounts 1,2,2,2,2,2,2,1,2,2,2,2,2,2,1,1 recover the plaintext of a ciphertext that was loaded under the same key.
- R6: Opcode 3 (read) applies the final permutation to {right, left}. The 64-bit result appears on `rdata_hi_o` and `rdata_lo_o` two edges after acceptance, with `rdata_valid_o` high for one cycle. The result words hold their value until the next read completes.
- R7: Opcode 4 (key restore) reloads C and D from the saved permuted-choice-1 value in one cycle, so a partly stepped key schedule is undone without resending the key.
- R8: For one cycle after a key load, data load or read is accepted, `cmd_ready_o` is low. A command presented during that cycle is not accepted and has no effect on the key or data state.
- R9: Round and key-restore commands take one cycle and leave `cmd_ready_o` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Engine can accept a command |
| cmd_op_i | input | 3 | Opcode: 0 key, 1 data, 2 round, 3 read, 4 key restore |
| cmd_imm_i | input | 2 | Round immediate: bit 0 decrypt, bit 1 rotate by two |
| cmd_hi_i | input | 32 | Upper operand word |
| cmd_lo_i | input | 32 | Lower operand word |
| rdata_hi_o | output | 32 | Upper result word |
| rdata_lo_o | output | 32 | Lower result word |
| rdata_valid_o | output | 1 | Result words updated this cycle |

## Verification
The bench checks complete encrypt and decrypt runs against published DES vectors. A mistake in any permutation table, any S-box entry, bit ordering, rotation direction or half swap would therefore produce a wrong 64-bit word. The decrypt runs would catch a design that rotates before taking the key, or rotates the wrong way, because that uses the wrong round key from round one. One test leaves a round command pending while the port is busy after a key load. An engine that accepted it would run an extra round and shift the key, and the final ciphertext would be wrong. Another test steps three rounds, restores the key and then runs a full block. If the restore were missing or stale, the key schedule would be offset and the result would be wrong.

// File: rtl/des_pkg.sv
package des_pkg;
  localparam int BLK_W  = 64;
  localparam int WORD_W = BLK_W / 2;
  localparam int CD_W   = 56;
  localparam int HALF_K = CD_W / 2;
  localparam int RK_W   = 48;
  localparam int N_SBOX = 8;
  localparam int OP_W   = 3;
  localparam int IMM_W  = 2;

  typedef enum logic [OP_W-1:0] {
    CMD_KEY   = 3'd0,
    CMD_DATA  = 3'd1,
    CMD_ROUND = 3'd2,
    CMD_READ  = 3'd3,
    CMD_REKEY = 3'd4
  } des_op_e;

  localparam int unsigned PC1_T [56] = '{
    57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,60,52,44,36,
    63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int unsigned PC2_T [48] = '{
    14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
    41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};
  localparam int unsigned PB_T [32] = '{
    16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};

  localparam logic [3:0] SB0 [64] = '{
    14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7, 0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
    4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0, 15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
  localparam logic [3:0] SB1 [64] = '{
    15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10, 3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
    0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15, 13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
  localparam logic [3:0] SB2 [64] = '{
    10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8, 13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
    13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7, 1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
  localparam logic [3:0] SB3 [64] = '{
    7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15, 13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
    10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4, 3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
  localparam logic [3:0] SB4 [64] = '{
    2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9, 14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
    4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14, 11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
  localparam logic [3:0] SB5 [64] = '{
    12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11, 10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
    9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6, 4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
  localparam logic [3:0] SB6 [64] = '{
    4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1, 13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
    1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2, 6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
  localparam logic [3:0] SB7 [64] = '{
    13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7, 1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
    7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8, 2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

  // Source bit (1 = MSB) feeding output bit j of the initial permutation.
  function automatic int ip_src(input int j);
    int r, c;
    r = (j - 1) / 8;
    c = (j - 1) % 8;
    return ((r < 4) ? (58 + 2 * r) : (57 + 2 * (r - 4))) - 8 * c;
  endfunction

  function automatic logic [BLK_W-1:0] init_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int j = 1; j <= BLK_W; j++) y[BLK_W-j] = x[BLK_W-ip_src(j)];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] final_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int j = 1; j <= BLK_W; j++) y[BLK_W-ip_src(j)] = x[BLK_W-j];
    return y;
  endfunction

  function automatic logic [RK_W-1:0] expand(input logic [WORD_W-1:0] x);
    logic [RK_W-1:0] y;
    y = '0;
    for (int g = 0; g < N_SBOX; g++)
      for (int k = 0; k < 6; k++)
        y[RK_W-1-(6*g+k)] = x[WORD_W-1-((4*g+k+WORD_W-1) % WORD_W)];
    return y;
  endfunction

  function automatic logic [WORD_W-1:0] pbox(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] y;
    y = '0;
    for (int j = 0; j < WORD_W; j++) y[WORD_W-1-j] = x[WORD_W-int'(PB_T[j])];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] pc1(input logic [BLK_W-1:0] x);
    logic [CD_W-1:0] y;
    y = '0;
    for (int j = 0; j < CD_W; j++) y[CD_W-1-j] = x[BLK_W-int'(PC1_T[j])];
    return y;
  endfunction

  function automatic logic [RK_W-1:0] pc2(input logic [CD_W-1:0] x);
    logic [RK_W-1:0] y;
    y = '0;
    for (int j = 0; j < RK_W; j++) y[RK_W-1-j] = x[CD_W-int'(PC2_T[j])];
    return y;
  endfunction

  function automatic logic [3:0] sbox(input int n, input logic [5:0] x);
    int idx;
    idx = int'({x[5], x[0]}) * 16 + int'(x[4:1]);
    case (n)
      0: return SB0[idx];
      1: return SB1[idx];
      2: return SB2[idx];
      3: return SB3[idx];
      4: return SB4[idx];
      5: return SB5[idx];
      6: return SB6[idx];
      default: return SB7[idx];
    endcase
  endfunction
endpackage

// File: rtl/des_cmd_ctl.sv
module des_cmd_ctl
  import des_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  output logic              ready_o,
  output logic              round_go_o,
  output logic              rekey_go_o,
  output logic              key_commit_o,
  output logic              data_commit_o,
  output logic              read_commit_o,
  output logic [BLK_W-1:0]  opnd_o
);
  logic    busy_q;
  des_op_e pend_q;
  logic    accept, slow_op;

  assign ready_o = !busy_q;
  assign accept  = valid_i && ready_o;
  assign slow_op = (des_op_e'(op_i) == CMD_KEY) || (des_op_e'(op_i) == CMD_DATA) ||
                   (des_op_e'(op_i) == CMD_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= CMD_KEY;
      opnd_o <= '0;
    end else begin
      busy_q <= accept && slow_op;
      if (accept && slow_op) begin
        pend_q <= des_op_e'(op_i);
        opnd_o <= {hi_i, lo_i};
      end
    end
  end

  assign round_go_o    = accept && (des_op_e'(op_i) == CMD_ROUND);
  assign rekey_go_o    = accept && (des_op_e'(op_i) == CMD_REKEY);
  assign key_commit_o  = busy_q && (pend_q == CMD_KEY);
  assign data_commit_o = busy_q && (pend_q == CMD_DATA);
  assign read_commit_o = busy_q && (pend_q == CMD_READ);
endmodule

// File: rtl/des_key_sched.sv
module des_key_sched
  import des_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BLK_W-1:0] key_i,
  input  logic             rekey_i,
  input  logic             step_i,
  input  logic             decrypt_i,
  input  logic             two_i,
  output logic [RK_W-1:0]  rkey_o
);
  logic [HALF_K-1:0] c_q, d_q, c_l, d_l, c_r, d_r;
  logic [CD_W-1:0]   saved_q;

  function automatic logic [HALF_K-1:0] rotl(input logic [HALF_K-1:0] v, input logic two);
    return two ? {v[HALF_K-3:0], v[HALF_K-1 -: 2]} : {v[HALF_K-2:0], v[HALF_K-1]};
  endfunction

  function automatic logic [HALF_K-1:0] rotr(input logic [HALF_K-1:0] v, input logic two);
    return two ? {v[1:0], v[HALF_K-1:2]} : {v[0], v[HALF_K-1:1]};
  endfunction

  assign c_l = rotl(c_q, two_i);
  assign d_l = rotl(d_q, two_i);
  assign c_r = rotr(c_q, two_i);
  assign d_r = rotr(d_q, two_i);

  // Encrypt keys off the rotated halves; decrypt keys off the current ones.
  assign rkey_o = decrypt_i ? pc2({c_q, d_q}) : pc2({c_l, d_l});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q     <= '0;
      d_q     <= '0;
      saved_q <= '0;
    end else if (load_i) begin
      saved_q    <= pc1(key_i);
      {c_q, d_q} <= pc1(key_i);
    end else if (rekey_i) begin
      {c_q, d_q} <= saved_q;
    end else if (step_i) begin
      c_q <= decrypt_i ? c_r : c_l;
      d_q <= decrypt_i ? d_r : d_l;
    end
  end
endmodule

// File: rtl/des_feistel.sv
module des_feistel
  import des_pkg::*;
(
  input  logic [WORD_W-1:0] r_i,
  input  logic [RK_W-1:0]   rkey_i,
  output logic [WORD_W-1:0] f_o
);
  logic [RK_W-1:0]   mixed;
  logic [WORD_W-1:0] s_out;

  assign mixed = expand(r_i) ^ rkey_i;

  for (genvar g = 0; g < N_SBOX; g++) begin : g_sbox
    assign s_out[WORD_W-1-4*g -: 4] = sbox(g, mixed[RK_W-1-6*g -: 6]);
  end

  assign f_o = pbox(s_out);
endmodule

// File: rtl/des_round_engine.sv
module des_round_engine
  import des_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [IMM_W-1:0]  cmd_imm_i,
  input  logic [WORD_W-1:0] cmd_hi_i,
  input  logic [WORD_W-1:0] cmd_lo_i,
  output logic [WORD_W-1:0] rdata_hi_o,
  output logic [WORD_W-1:0] rdata_lo_o,
  output logic              rdata_valid_o
);
  logic              round_go, rekey_go, key_commit, data_commit, read_commit;
  logic [BLK_W-1:0]  opnd;
  logic [RK_W-1:0]   rkey;
  logic [WORD_W-1:0] l_q, r_q, f_val;

  des_cmd_ctl u_ctl (
    .clk_i, .rst_ni,
    .valid_i      (cmd_valid_i),
    .op_i         (cmd_op_i),
    .hi_i         (cmd_hi_i),
    .lo_i         (cmd_lo_i),
    .ready_o      (cmd_ready_o),
    .round_go_o   (round_go),
    .rekey_go_o   (rekey_go),
    .key_commit_o (key_commit),
    .data_commit_o(data_commit),
    .read_commit_o(read_commit),
    .opnd_o       (opnd)
  );

  des_key_sched u_ks (
    .clk_i, .rst_ni,
    .load_i   (key_commit),
    .key_i    (opnd),
    .rekey_i  (rekey_go),
    .step_i   (round_go),
    .decrypt_i(cmd_imm_i[0]),
    .two_i    (cmd_imm_i[1]),
    .rkey_o   (rkey)
  );

  des_feistel u_f (
    .r_i   (r_q),
    .rkey_i(rkey),
    .f_o   (f_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q <= '0;
      r_q <= '0;
    end else if (data_commit) begin
      {l_q, r_q} <= init_perm(opnd);
    end else if (round_go) begin
      l_q <= r_q;
      r_q <= l_q ^ f_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_hi_o    <= '0;
      rdata_lo_o    <= '0;
      rdata_valid_o <= 1'b0;
    end else begin
      rdata_valid_o <= read_commit;
      if (read_commit) {rdata_hi_o, rdata_lo_o} <= final_perm({r_q, l_q});
    end
  end
endmodule

// File: rtl/des_round_engine_chk.sv
module des_round_engine_chk
  import des_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [OP_W-1:0]   cmd_op_i,
  input logic [WORD_W-1:0] rdata_hi_o,
  input logic [WORD_W-1:0] rdata_lo_o,
  input logic              rdata_valid_o
);
  logic acc, acc_slow, acc_fast, acc_read;
  assign acc      = cmd_valid_i && cmd_ready_o;
  assign acc_read = acc && (cmd_op_i == 3'd3);
  assign acc_slow = acc && (cmd_op_i == 3'd0 || cmd_op_i == 3'd1 || cmd_op_i == 3'd3);
  assign acc_fast = acc && (cmd_op_i == 3'd2 || cmd_op_i == 3'd4);

  a_r8_busy_after_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_slow |=> !cmd_ready_o);
  a_r8_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o |=> cmd_ready_o);
  a_r9_fast_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fast |=> cmd_ready_o);
  a_r6_valid_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $past(acc_read, 2));
  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !rdata_valid_o);
  a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_valid_o |-> ($stable(rdata_hi_o) && $stable(rdata_lo_o)));
endmodule

bind des_round_engine des_round_engine_chk u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_op_i,
  .rdata_hi_o, .rdata_lo_o, .rdata_valid_o
);

// File: tb/sim_des_round_engine.sv
module sim_des_round_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_KEY = 3'd0, OP_DATA = 3'd1, OP_RND = 3'd2,
                         OP_READ = 3'd3, OP_REKEY = 3'd4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid_i = 1'b0, cmd_ready_o;
  logic [2:0]  cmd_op_i = '0;
  logic [1:0]  cmd_imm_i = '0;
  logic [31:0] cmd_hi_i = '0, cmd_lo_i = '0, rdata_hi_o, rdata_lo_o;
  logic        rdata_valid_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  des_round_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_imm_i,
    .cmd_hi_i, .cmd_lo_i, .rdata_hi_o, .rdata_lo_o, .rdata_valid_o
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Rotation amount of round i (1..16), from R4 / R5.
  function automatic logic two_of(input bit dec, input int i);
    if (dec) return !(i == 1 || i == 8 || i == 15 || i == 16);
    return !(i == 1 || i == 2 || i == 9 || i == 16);
  endfunction

  task automatic send(input logic [2:0] op, input logic [63:0] v, input logic [1:0] imm);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_imm_i = imm;
    {cmd_hi_i, cmd_lo_i} = v;
    while (!cmd_ready_o) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid_i = 1'b0;
  endtask

  task automatic read_out(output logic [63:0] v);
    send(OP_READ, '0, 2'b00);
    v = 'x;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (rdata_valid_o) begin
        v = {rdata_hi_o, rdata_lo_o};
        break;
      end
    end
  endtask

  task automatic run16(input bit dec);
    for (int i = 1; i <= 16; i++) send(OP_RND, '0, {two_of(dec, i), dec});
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R1 ready after reset", {63'd0, cmd_ready_o}, 64'd1);
    read_out(v);
    chk("R1 result of reset state", v, 64'd0);
  endtask

  task automatic t_block(input bit dec, input logic [63:0] key, input logic [63:0] din,
                         input logic [63:0] exp, input string tag);
    logic [63:0] v;
    send(OP_KEY, key, 2'b00);
    send(OP_DATA, din, 2'b00);
    run16(dec);
    read_out(v);
    chk(tag, v, exp);
  endtask

  task automatic t_busy_reject;
    logic [63:0] v;
    send(OP_KEY, 64'h133457799BBCDFF1, 2'b00);
    @(negedge clk);
    chk("R8 ready low after key load", {63'd0, cmd_ready_o}, 64'd0);
    cmd_valid_i = 1'b1; cmd_op_i = OP_RND; cmd_imm_i = 2'b00;
    @(posedge clk);
    #1 cmd_valid_i = 1'b0;
    @(negedge clk);
    chk("R8 ready back one cycle later", {63'd0, cmd_ready_o}, 64'd1);
    send(OP_DATA, 64'h0123456789ABCDEF, 2'b00);
    run16(1'b0);
    read_out(v);
    chk("R8 stray round ignored", v, 64'h85E813540F0AB405);
    @(negedge clk);
    chk("R6 result held after pulse", {rdata_hi_o, rdata_lo_o}, 64'h85E813540F0AB405);
    chk("R6 valid is a pulse", {63'd0, rdata_valid_o}, 64'd0);
  endtask

  task automatic t_rekey;
    logic [63:0] v;
    send(OP_KEY, 64'h0E329232EA6D0D73, 2'b00);
    send(OP_DATA, 64'h8787878787878787, 2'b00);
    for (int i = 1; i <= 3; i++) send(OP_RND, '0, {two_of(1'b0, i), 1'b0});
    send(OP_REKEY, '0, 2'b00);
    @(negedge clk);
    chk("R9 ready after restore", {63'd0, cmd_ready_o}, 64'd1);
    send(OP_DATA, 64'h8787878787878787, 2'b00);
    run16(1'b0);
    read_out(v);
    chk("R7 restore undoes partial schedule", v, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_block(1'b0, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405,
            "R2 R3 R4 R6 encrypt vector A");
    t_block(1'b1, 64'h133457799BBCDFF1, 64'h85E813540F0AB405, 64'h0123456789ABCDEF,
            "R5 decrypt vector A");
    t_block(1'b0, 64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0,
            "R4 encrypt vector B");
    t_block(1'b1, 64'h0E329232EA6D0D73, 64'h0, 64'h8787878787878787,
            "R5 decrypt vector B");
    t_block(1'b0, 64'h0, 64'h0, 64'h8CA64DE9C1B123A7, "R4 encrypt zero key");
    t_block(1'b1, 64'h0, 64'h8CA64DE9C1B123A7, 64'h0, "R5 decrypt zero key");
    send(OP_RND, '0, 2'b00);
    @(negedge clk);
    chk("R9 round leaves port ready", {63'd0, cmd_ready_o}, 64'd1);
    t_busy_reject();
    t_rekey();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule